// File: doc/BRIEF.md
# Accumulator Instruction Execute Unit

This block executes one 13-bit instruction per accepted transfer for a small single-accumulator controller. It holds an 8-bit accumulator, a file of 64 byte-wide registers selected by a 6-bit field, the zero, carry and half-carry flags, a control byte, an interrupt-enable bit and a circular return stack. A fetch stage offers an instruction word together with the program counter it came from. The unit answers with the address of the next instruction and the effects of the executed instruction.

The instruction input is a valid/ready stream. A word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the producer keeps `in_valid`, `instr` and `pc_in` unchanged. `in_ready` drops only for the single cycle that follows an accepted instruction whose destination is register 2, the program counter, and only when `cfg_pc_two_cycle` is high. That cycle is the extra cycle the fetch side spends on the redirected path. Results, `done` and `long_cyc` are registered and appear in the cycle after acceptance. The outputs have no back-pressure. The return stack is filled through a plain push port driven by the call logic outside the block, and a debug port reads any register address combinationally.

Top module: `acc_exec_unit`

## Requirements
- R1: After reset the accumulator, all flags, the control byte, the interrupt enable, `next_pc`, `done`, `long_cyc` and every stored register read 0, and `in_ready` is 1.
- R2: An instruction transfers only when `in_valid` and `in_ready` are both high. In the next cycle `done` is 1 and `next_pc` is `pc_in+1`, unless R3 or R10 applies.
- R3: An instruction that writes register address 2 sets `next_pc` to {`pc_in` upper bits, result byte}. When `cfg_pc_two_cycle` is 1, `long_cyc` is 1 with that `done`, and `in_ready` is 0 for exactly that one cycle. When `cfg_pc_two_cycle` is 0, `in_ready` stays 1.
- R4: Word 0x040|r copies the accumulator into register r and leaves the flags unchanged, unless r is 3.
- R5: Word 0x080 clears the accumulator and word 0x0C0|r clears register r. Both set Z and leave C and DC unchanged.
- R6: Word 0x100|r writes R−A into the accumulator and word 0x140|r writes R−A into register r. Z is set for a zero result, C=1 when R≥A, and DC=1 when R[3:0]≥A[3:0].
- R7: Word 0x180|r writes R−1 into the accumulator and word 0x1C0|r writes R−1 into register r. Only Z changes.
- R8: Word 0x002 copies the accumulator into the control byte and word 0x014 copies the control byte into the accumulator. No flag changes.
- R9: Word 0x010 sets the interrupt enable and 0x011 clears it. Word 0x013 also sets it.
- R10: Words 0x012 and 0x013 pop the top of an 8-entry return stack into `next_pc`. Each `push_en` cycle stores `push_pc`. A ninth push overwrites the oldest entry, and a pop from the emptied stack wraps around. A push in the same cycle as an accepted pop is dropped.
- R11: Register address 3 is the status byte: bit0 C, bit1 DC, bit2 Z, upper bits 0. Writing it loads the flags, and any flag the instruction itself updates overrides the loaded value. Reading address 2 returns `pc_in[7:0]`.
- R12: Any other instruction word acts as a no-operation: no state changes and `next_pc` is `pc_in+1`.
- R13: While `in_valid` is low no state changes and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pc_two_cycle | input | 1 | 1 = writes to the program-counter register take an extra cycle |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take an instruction |
| instr | input | 13 | Instruction word |
| pc_in | input | PCW | Address of the offered instruction |
| push_en | input | 1 | Push `push_pc` onto the return stack |
| push_pc | input | PCW | Return address to push |
| dbg_addr | input | 6 | Register address to read |
| dbg_data | output | 8 | Register contents at `dbg_addr` |
| acc_out | output | 8 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry (no-borrow) flag |
| flag_dc | output | 1 | Half-carry (no nibble borrow) flag |
| ctrl_out | output | 8 | Control byte |
| ie_en | output | 1 | Interrupt enable |
| next_pc | output | PCW | Address of the next instruction |
| done | output | 1 | Pulses for one cycle after each accepted instruction |
| long_cyc | output | 1 | The instruction just completed used two cycles |

## Verification
The bench probes subtraction at equal operands, at a borrow only in the low nibble, at a borrow only in the high part, and at a borrow in both. A design with the carry or half-carry sense inverted, or with the nibble compare taken on the wrong bits, flags those cases wrongly. It writes register 2 with the extra-cycle option both off and on while holding a different word at the input. A unit that skips the stall would take that word, and one that stalls too long would drop the next word. It also targets writes to the status address that race the instruction's own flag update, returns after more than eight pushes, and undefined words. A decoder that matches loosely would change state on those words, and a stack without wrap would return the wrong address.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
  localparam int DW  = 8;
  localparam int RAW = 6;
  localparam int IW  = 13;
  localparam int NREG = 1 << RAW;
  localparam logic [RAW-1:0] PC_ADDR   = 6'd2;
  localparam logic [RAW-1:0] STAT_ADDR = 6'd3;

  typedef enum logic [3:0] {
    OP_NOP, OP_CTLW, OP_CTLR, OP_EI, OP_DI, OP_RET, OP_RETI,
    OP_MOVR, OP_CLRA, OP_CLRR, OP_SUBA, OP_SUBR, OP_DECA, OP_DECR
  } op_e;

  typedef struct packed {
    op_e            op;
    logic           wr_acc;
    logic           wr_reg;
    logic [RAW-1:0] ra;
  } dec_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_exec_pkg::*;
(
  input  logic [IW-1:0] instr,
  output dec_t          dec
);
  logic [6:0] grp;
  assign grp = instr[12:6];

  always_comb begin
    dec.op     = OP_NOP;
    dec.wr_acc = 1'b0;
    dec.wr_reg = 1'b0;
    dec.ra     = instr[RAW-1:0];
    case (grp)
      7'b0000000: begin
        case (instr[5:0])
          6'h02: dec.op = OP_CTLW;
          6'h10: dec.op = OP_EI;
          6'h11: dec.op = OP_DI;
          6'h12: dec.op = OP_RET;
          6'h13: dec.op = OP_RETI;
          6'h14: dec.op = OP_CTLR;
          default: dec.op = OP_NOP;
        endcase
      end
      7'b0000001: begin dec.op = OP_MOVR; dec.wr_reg = 1'b1; end
      7'b0000010: begin
        if (instr[5:0] == 6'h00) begin dec.op = OP_CLRA; dec.wr_acc = 1'b1; end
      end
      7'b0000011: begin dec.op = OP_CLRR; dec.wr_reg = 1'b1; end
      7'b0000100: begin dec.op = OP_SUBA; dec.wr_acc = 1'b1; end
      7'b0000101: begin dec.op = OP_SUBR; dec.wr_reg = 1'b1; end
      7'b0000110: begin dec.op = OP_DECA; dec.wr_acc = 1'b1; end
      7'b0000111: begin dec.op = OP_DECR; dec.wr_reg = 1'b1; end
      default: dec.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] r,
  output logic [DW-1:0] res,
  output logic          z,
  output logic          c,
  output logic          dc,
  output logic          upd_z,
  output logic          upd_cdc
);
  localparam int HW = DW / 2;
  logic [DW:0] diff;
  logic [HW:0] lo_diff;

  assign diff    = {1'b0, r} - {1'b0, a};
  assign lo_diff = {1'b0, r[HW-1:0]} - {1'b0, a[HW-1:0]};
  assign c       = ~diff[DW];
  assign dc      = ~lo_diff[HW];
  assign z       = (res == '0);

  always_comb begin
    res     = '0;
    upd_z   = 1'b0;
    upd_cdc = 1'b0;
    case (op)
      OP_MOVR:          res = a;
      OP_CLRA, OP_CLRR: upd_z = 1'b1;
      OP_SUBA, OP_SUBR: begin res = diff[DW-1:0]; upd_z = 1'b1; upd_cdc = 1'b1; end
      OP_DECA, OP_DECR: begin res = r - DW'(1); upd_z = 1'b1; end
      default:          res = '0;
    endcase
  end
endmodule

// File: rtl/acc_ret_stack.sv
module acc_ret_stack #(
  parameter int DEPTH = 8,
  parameter int PCW   = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [PCW-1:0] push_val,
  input  logic           pop,
  output logic [PCW-1:0] top
);
  localparam int SPW = $clog2(DEPTH);
  logic [SPW-1:0] sp;
  logic [PCW-1:0] mem [DEPTH];

  assign top = mem[sp - SPW'(1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else if (pop) sp <= sp - SPW'(1);
    else if (push) sp <= sp + SPW'(1);
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[gi] <= '0;
      else if (push && !pop && sp == SPW'(gi)) mem[gi] <= push_val;
    end
  end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int PCW       = 10,
  parameter int STK_DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_pc_two_cycle,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [12:0]    instr,
  input  logic [PCW-1:0] pc_in,
  input  logic           push_en,
  input  logic [PCW-1:0] push_pc,
  input  logic [5:0]     dbg_addr,
  output logic [7:0]     dbg_data,
  output logic [7:0]     acc_out,
  output logic           flag_z,
  output logic           flag_c,
  output logic           flag_dc,
  output logic [7:0]     ctrl_out,
  output logic           ie_en,
  output logic [PCW-1:0] next_pc,
  output logic           done,
  output logic           long_cyc
);
  dec_t          d;
  logic          accept, busy_q, is_ret, pc_wr, stat_wr, rf_we;
  logic [DW-1:0] acc_q, ctrl_q, rval, res;
  logic [DW-1:0] rf [NREG];
  logic          z_q, c_q, dc_q, alu_z, alu_c, alu_dc, upd_z, upd_cdc;
  logic          z_n, c_n, dc_n;
  logic [DW-1:0] stat_byte;
  logic [PCW-1:0] stk_top, pc_n;

  acc_decode u_dec (.instr(instr), .dec(d));

  assign stat_byte = {5'b0, z_q, dc_q, c_q};

  function automatic logic [DW-1:0] rd_reg(input logic [RAW-1:0] a,
                                           input logic [PCW-1:0] pc,
                                           input logic [DW-1:0] st);
    if (a == PC_ADDR)        return pc[DW-1:0];
    else if (a == STAT_ADDR) return st;
    else                     return rf[a];
  endfunction

  assign rval     = rd_reg(d.ra, pc_in, stat_byte);
  assign dbg_data = rd_reg(dbg_addr, pc_in, stat_byte);

  acc_alu u_alu (
    .op(d.op), .a(acc_q), .r(rval), .res(res), .z(alu_z), .c(alu_c),
    .dc(alu_dc), .upd_z(upd_z), .upd_cdc(upd_cdc)
  );

  assign in_ready = ~busy_q;
  assign accept   = in_valid & in_ready;
  assign is_ret   = (d.op == OP_RET) || (d.op == OP_RETI);
  assign pc_wr    = accept & d.wr_reg & (d.ra == PC_ADDR);
  assign stat_wr  = accept & d.wr_reg & (d.ra == STAT_ADDR);
  assign rf_we    = accept & d.wr_reg & (d.ra != PC_ADDR) & (d.ra != STAT_ADDR);

  acc_ret_stack #(.DEPTH(STK_DEPTH), .PCW(PCW)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push_en & ~(accept & is_ret)),
    .push_val(push_pc), .pop(accept & is_ret), .top(stk_top)
  );

  always_comb begin
    {z_n, dc_n, c_n} = stat_wr ? res[2:0] : {z_q, dc_q, c_q};
    if (accept && upd_z)   z_n = alu_z;
    if (accept && upd_cdc) begin c_n = alu_c; dc_n = alu_dc; end
    if (accept && is_ret)  pc_n = stk_top;
    else if (pc_wr)        pc_n = {pc_in[PCW-1:DW], res};
    else                   pc_n = pc_in + PCW'(1);
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_rf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rf[gi] <= '0;
      else if (rf_we && d.ra == RAW'(gi)) rf[gi] <= res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; ctrl_q <= '0; ie_en <= 1'b0;
      z_q <= 1'b0; c_q <= 1'b0; dc_q <= 1'b0;
      next_pc <= '0; done <= 1'b0; long_cyc <= 1'b0; busy_q <= 1'b0;
    end else begin
      done     <= accept;
      long_cyc <= pc_wr & cfg_pc_two_cycle;
      busy_q   <= pc_wr & cfg_pc_two_cycle;
      z_q <= z_n; c_q <= c_n; dc_q <= dc_n;
      if (accept) begin
        next_pc <= pc_n;
        if (d.wr_acc) acc_q <= res;
        case (d.op)
          OP_CTLW:        ctrl_q <= acc_q;
          OP_CTLR:        acc_q  <= ctrl_q;
          OP_EI, OP_RETI: ie_en  <= 1'b1;
          OP_DI:          ie_en  <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign acc_out  = acc_q;
  assign ctrl_out = ctrl_q;
  assign flag_z   = z_q;
  assign flag_c   = c_q;
  assign flag_dc  = dc_q;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [12:0] instr,
  input logic        done,
  input logic        long_cyc,
  input logic [7:0]  acc_out,
  input logic        flag_z,
  input logic        flag_c,
  input logic        flag_dc,
  input logic        ie_en
);
  // R3
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
  // R3
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (done && long_cyc));
  // R9
  ie_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && instr == 13'h010) |=> ie_en);
  // R5
  clra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && instr == 13'h080) |=> (acc_out == 8'h00 && flag_z));
  // R4
  mov_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && instr[12:6] == 7'b0000001 && instr[5:0] != 6'd3)
    |=> ($stable(flag_z) && $stable(flag_c) && $stable(flag_dc)));
  // R13
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && $stable(acc_out)));
endmodule

bind acc_exec_unit acc_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .instr(instr), .done(done), .long_cyc(long_cyc), .acc_out(acc_out),
  .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc), .ie_en(ie_en)
);

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
  localparam int PCW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg, in_valid, in_ready, push_en, done, long_cyc;
  logic flag_z, flag_c, flag_dc, ie_en;
  logic [12:0] instr;
  logic [PCW-1:0] pc_in, push_pc, next_pc;
  logic [5:0] dbg_addr;
  logic [7:0] dbg_data, acc_out, ctrl_out;

  acc_exec_unit #(.PCW(PCW), .STK_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pc_two_cycle(cfg), .in_valid(in_valid),
    .in_ready(in_ready), .instr(instr), .pc_in(pc_in), .push_en(push_en),
    .push_pc(push_pc), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .acc_out(acc_out), .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc),
    .ctrl_out(ctrl_out), .ie_en(ie_en), .next_pc(next_pc), .done(done),
    .long_cyc(long_cyc)
  );

  int vecs = 0, errs = 0;

  // reference state
  logic [7:0] m_acc = 0, m_ctrl = 0;
  logic [7:0] m_rf [64];
  logic m_z = 0, m_c = 0, m_dc = 0, m_ie = 0, m_busy = 0, m_done = 0, m_long = 0;
  logic [PCW-1:0] m_npc = 0;
  logic [PCW-1:0] m_stk [8];
  int m_sp = 0;

  function automatic logic [7:0] mrd(input logic [5:0] a, input logic [PCW-1:0] pc);
    if (a == 6'd2) return pc[7:0];
    if (a == 6'd3) return {5'b0, m_z, m_dc, m_c};
    return m_rf[a];
  endfunction

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic [12:0] ins,
                       input logic [PCW-1:0] pc, input logic cf,
                       input logic pe, input logic [PCW-1:0] pv);
    logic acc_ok, wr_r, wr_a, uz, uc, popped;
    logic [7:0] r, res;
    logic [6:0] hi;
    logic [5:0] lo;
    logic [PCW-1:0] npc;
    in_valid = v; instr = ins; pc_in = pc; cfg = cf; push_en = pe; push_pc = pv;
    dbg_addr = ins[5:0];
    acc_ok = v && !m_busy;
    hi = ins[12:6]; lo = ins[5:0];
    wr_r = 0; wr_a = 0; uz = 0; uc = 0; popped = 0; res = 0;
    m_long = 0;
    m_done = acc_ok;
    m_busy = 0;
    if (acc_ok) begin
      r = mrd(lo, pc);
      npc = pc + 1;
      if (hi == 0) begin
        if (lo == 6'h02) m_ctrl = m_acc;
        else if (lo == 6'h14) m_acc = m_ctrl;
        else if (lo == 6'h10) m_ie = 1;
        else if (lo == 6'h11) m_ie = 0;
        else if (lo == 6'h12 || lo == 6'h13) begin
          m_sp = (m_sp + 7) % 8; npc = m_stk[m_sp]; popped = 1;
          if (lo == 6'h13) m_ie = 1;
        end
      end else if (hi == 1) begin res = m_acc; wr_r = 1; end
      else if (hi == 2 && lo == 0) begin res = 0; wr_a = 1; uz = 1; end
      else if (hi == 3) begin res = 0; wr_r = 1; uz = 1; end
      else if (hi == 4 || hi == 5) begin
        res = r - m_acc; uz = 1; uc = 1;
        wr_a = (hi == 4); wr_r = (hi == 5);
      end else if (hi == 6 || hi == 7) begin
        res = r - 1; uz = 1; wr_a = (hi == 6); wr_r = (hi == 7);
      end
      if (wr_a) m_acc = res;
      if (wr_r) begin
        if (lo == 2) begin npc = {pc[PCW-1:8], res}; m_long = cf; m_busy = cf; end
        else if (lo == 3) {m_z, m_dc, m_c} = res[2:0];
        else m_rf[lo] = res;
      end
      if (uz) m_z = (res == 0);
      if (uc) begin m_c = (r >= m_acc_prev(hi, r, res)); m_dc = (r[3:0] >= sub_a_lo(r, res)); end
      m_npc = npc;
    end
    if (pe && !popped) begin m_stk[m_sp] = pv; m_sp = (m_sp + 1) % 8; end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "in_ready", in_ready, !m_busy);
    chk(tag, "done", done, m_done);
    chk(tag, "long_cyc", long_cyc, m_long);
    chk(tag, "acc", acc_out, m_acc);
    chk(tag, "flags", {flag_z, flag_dc, flag_c}, {m_z, m_dc, m_c});
    chk(tag, "ctrl", ctrl_out, m_ctrl);
    chk(tag, "ie", ie_en, m_ie);
    chk(tag, "next_pc", next_pc, m_npc);
    chk(tag, "dbg_data", dbg_data, mrd(ins[5:0], pc));
  endtask

  // the subtrahend A is recovered from R and R-A: A = R - res (mod 256)
  function automatic logic [7:0] m_acc_prev(input logic [6:0] hi, input logic [7:0] r, input logic [7:0] res);
    return (hi == 4 || hi == 5) ? (r - res) : 8'h00;
  endfunction
  function automatic logic [3:0] sub_a_lo(input logic [7:0] r, input logic [7:0] res);
    logic [7:0] a;
    a = r - res;
    return a[3:0];
  endfunction

  task automatic load_a(input string tag, input logic [7:0] x);
    apply(tag, 1, 13'h080, 10'h100, 0, 0, 0);
    apply(tag, 1, 13'h102, {2'b01, x}, 0, 0, 0);   // A = pc_low - 0
  endtask

  task automatic sub_case(input string tag, input logic [7:0] rv, input logic [7:0] av);
    load_a(tag, rv);
    apply(tag, 1, 13'h045, 10'h010, 0, 0, 0);       // R5 = rv
    load_a(tag, av);
    apply(tag, 1, 13'h105, 10'h020, 0, 0, 0);       // A = R5 - A
    load_a(tag, av);
    apply(tag, 1, 13'h145, 10'h030, 0, 0, 0);       // R5 = R5 - A
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_rf[i] = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    rst_n = 0; cfg = 0; in_valid = 0; instr = 0; pc_in = 0;
    push_en = 0; push_pc = 0; dbg_addr = 6'd7;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1", "acc", acc_out, 0);
    chk("R1", "flags", {flag_z, flag_dc, flag_c}, 0);
    chk("R1", "ctrl", ctrl_out, 0);
    chk("R1", "ie", ie_en, 0);
    chk("R1", "next_pc", next_pc, 0);
    chk("R1", "ready", in_ready, 1);
    chk("R1", "rf7", dbg_data, 0);
    // R13 valid low with a live opcode
    apply("R13", 0, 13'h080, 10'h005, 0, 0, 0);
    apply("R13", 0, 13'h105, 10'h005, 0, 0, 0);
    // R2 plain flow, R12 undefined words
    apply("R2", 1, 13'h000, 10'h3FF, 0, 0, 0);
    apply("R12", 1, 13'h001, 10'h021, 0, 0, 0);
    apply("R12", 1, 13'h0A5, 10'h022, 0, 0, 0);
    apply("R12", 1, 13'h015, 10'h023, 0, 0, 0);
    apply("R12", 1, 13'h1FFF, 10'h024, 0, 0, 0);
    // R4 move, R7 decrement
    load_a("R4", 8'hA7);
    apply("R4", 1, 13'h04A, 10'h040, 0, 0, 0);
    apply("R7", 1, 13'h1CB, 10'h041, 0, 0, 0);      // R11 = 0 - 1 = FF
    apply("R7", 1, 13'h18B, 10'h042, 0, 0, 0);      // A = FE
    load_a("R7", 8'h01);
    apply("R7", 1, 13'h04C, 10'h043, 0, 0, 0);
    apply("R7", 1, 13'h1CC, 10'h044, 0, 0, 0);      // zero result
    // R6 borrow corners
    sub_case("R6", 8'h35, 8'h35);
    sub_case("R6", 8'h30, 8'h05);
    sub_case("R6", 8'h05, 8'h30);
    sub_case("R6", 8'h03, 8'h14);
    sub_case("R6", 8'h00, 8'hFF);
    // R5 clears keep C/DC
    apply("R5", 1, 13'h0CA, 10'h050, 0, 0, 0);
    apply("R5", 1, 13'h080, 10'h051, 0, 0, 0);
    // R8 control byte
    load_a("R8", 8'h5C);
    apply("R8", 1, 13'h002, 10'h060, 0, 0, 0);
    apply("R8", 1, 13'h080, 10'h061, 0, 0, 0);
    apply("R8", 1, 13'h014, 10'h062, 0, 0, 0);
    // R9 interrupt enable
    apply("R9", 1, 13'h010, 10'h070, 0, 0, 0);
    apply("R9", 1, 13'h011, 10'h071, 0, 0, 0);
    // R10 stack with wrap
    for (int i = 0; i < 9; i++) apply("R10", 0, 13'h000, 10'h080, 0, 1, PCW'(10'h200 + i));
    for (int i = 0; i < 10; i++) apply("R10", 1, (i % 2) ? 13'h013 : 13'h012, 10'h090, 0, 0, 0);
    apply("R10", 1, 13'h012, 10'h091, 0, 1, 10'h155);   // push dropped
    // R11 status address
    load_a("R11", 8'h07);
    apply("R11", 1, 13'h043, 10'h0A0, 0, 0, 0);
    apply("R11", 1, 13'h0C3, 10'h0A1, 0, 0, 0);
    load_a("R11", 8'h02);
    apply("R11", 1, 13'h143, 10'h0A2, 0, 0, 0);
    apply("R11", 1, 13'h182, 10'h2B7, 0, 0, 0);
    // R3 program counter writes
    load_a("R3", 8'h3C);
    apply("R3", 1, 13'h042, 10'h2F0, 0, 0, 0);
    apply("R3", 1, 13'h042, 10'h1F0, 1, 0, 0);
    apply("R3", 1, 13'h080, 10'h1F1, 1, 0, 0);     // held during stall
    apply("R3", 1, 13'h080, 10'h1F1, 1, 0, 0);
    apply("R3", 1, 13'h1C2, 10'h300, 1, 0, 0);
    apply("R3", 1, 13'h0C2, 10'h301, 1, 0, 0);
    apply("R3", 1, 13'h0C2, 10'h301, 0, 0, 0);
    // mixed sweep
    for (int i = 0; i < 400; i++)
      apply("R2", ($urandom % 4) != 0, 13'($urandom % 13'h200), PCW'($urandom),
            ($urandom % 2) == 1, ($urandom % 5) == 0, PCW'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule